// File: doc/BRIEF.md
# Serial Memory Read Port (SPI Slave)

This block is an SPI slave that answers read commands from an on-chip word array. A master pulls the select line low, shifts in an 8-bit command and then an address field. The block then streams stored words back on its serial output, most significant bit first, for as long as the select stays low. The serial clock, select and data input are brought into the system clock domain by synchronizer flops, and SCK edges are detected there. SI is taken on rising SCK and SO is updated on falling SCK, which is SPI mode 0.

The `MODE` parameter selects one of two variants. In `MODE_EXT` the address field is 16 bits wide, of which only the low 9 bits select a word. Words are 16 bits, and the address wraps from the top of the 512-word array back to zero. In `MODE_BASE` the address is 8 bits and the data are 8-bit bytes. Streaming stops after the top byte, and SO is released from that point on.

A busy input stands for internal programming in progress, and while it is set, read commands are refused. A synchronous preload port fills the array while the select is high. The serial output is a data bit plus an enable bit, so that any external pad can build the tri-state driver.

Top module: `spi_rd_slave`

## Requirements
- R1: While cs_ni is high, so_oe_o is 0. A rising cs_ni ends any data stream in progress, and the next transaction starts fresh from the command phase.
- R2: The read command is the byte 0x03, sent MSB first on si_i. Any other byte leaves so_oe_o at 0 for the rest of the transaction.
- R3: If busy_i is 1 when the 8th command bit is sampled, the read is refused and so_oe_o stays 0 until cs_ni rises.
- R4: In MODE_EXT the 16-bit address field follows the command MSB first. Only its last 9 bits received (bits 8..0) select the word, and the first 7 bits are discarded.
- R5: so_oe_o is 0 during the command and address phases. Data bits change on falling SCK. The first data MSB is valid at the first rising SCK after the last address bit, and each word goes out MSB first.
- R6: In MODE_EXT the word address increments after every 16 data bits, and it wraps from 511 to 0 without a break in the stream.
- R7: In MODE_BASE an 8-bit address follows the command. 8-bit bytes stream out with an incrementing address up to 255.
- R8: In MODE_BASE, once all 8 bits of address 255 have been shifted out, so_oe_o is 0 for the rest of the transaction. The address does not roll over.
- R9: When pre_we_i is 1 at a rising clk_i edge, pre_data_i is stored at pre_addr_i. A later read of that address returns that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | SPI serial clock (mode 0) |
| cs_ni | input | 1 | Active-low chip select |
| si_i | input | 1 | Serial data in |
| busy_i | input | 1 | Internal programming in progress; refuses reads |
| pre_we_i | input | 1 | Preload write enable (use only with cs_ni high) |
| pre_addr_i | input | AW | Preload word address |
| pre_data_i | input | WW | Preload word data |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for so_o (0 = high impedance) |

## Verification
The bench preloads distinct pseudo-random contents into an extended-mode instance and a base-mode instance, then runs reads from several start points. Reads from a mid-array address, with the discarded upper address bits set to ones, separate a correct 9-bit address decode from one that keeps the wrong bits. A read starting at 510 shows whether the address wraps to 0, and a base read starting at 253 shows whether the output stops after 255 or rolls over. The same shifted patterns are also sent with a wrong command byte, with busy set, and with the select raised in the middle of a word. Each of these must leave the output disabled, which tells refusal and stream termination apart from ordinary streaming.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;
  typedef enum logic {MODE_EXT, MODE_BASE} mode_e;
  typedef enum logic [1:0] {ST_OPC, ST_ADR, ST_DATA, ST_IGN} rd_state_e;
  localparam logic [7:0] READ_OP = 8'h03;
endpackage

// File: rtl/spi_rd_sync.sv
module spi_rd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic cs_ni,
  input  logic si_i,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic cs_o,
  output logic si_o
);
  logic [STAGES:0]   sck_sr;
  logic [STAGES-1:0] cs_sr;
  logic [STAGES-1:0] si_sr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_sr <= '0;
      cs_sr  <= '1;
      si_sr  <= '0;
    end else begin
      sck_sr <= {sck_sr[STAGES-1:0], sck_i};
      cs_sr  <= {cs_sr[STAGES-2:0], cs_ni};
      si_sr  <= {si_sr[STAGES-2:0], si_i};
    end
  end

  assign sck_rise_o = sck_sr[STAGES-1] & ~sck_sr[STAGES];
  assign sck_fall_o = ~sck_sr[STAGES-1] & sck_sr[STAGES];
  assign cs_o       = cs_sr[STAGES-1];
  assign si_o       = si_sr[STAGES-1];
endmodule

// File: rtl/spi_rd_array.sv
module spi_rd_array #(
  parameter int AW = 9,
  parameter int WW = 16
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [WW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [WW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [WW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/spi_rd_ctrl.sv
module spi_rd_ctrl
  import spi_rd_pkg::*;
#(
  parameter mode_e MODE = MODE_EXT,
  parameter int    AW   = 9,
  parameter int    WW   = 16,
  parameter int    FW   = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sck_rise_i,
  input  logic          sck_fall_i,
  input  logic          cs_i,
  input  logic          si_i,
  input  logic          busy_i,
  output logic [AW-1:0] rd_addr_o,
  input  logic [WW-1:0] rd_data_i,
  output logic          so_o,
  output logic          so_oe_o
);
  localparam int            CW       = $clog2(FW) + 1;
  localparam int            BW       = $clog2(WW);
  localparam logic [AW-1:0] TOP      = {AW{1'b1}};
  localparam logic [CW-1:0] OPC_LAST = CW'(7);
  localparam logic [CW-1:0] ADR_LAST = CW'(FW - 1);
  localparam logic [BW-1:0] BIT_LAST = BW'(WW - 1);

  rd_state_e     state_q;
  logic [7:0]    op_q, op_nxt;
  logic [AW-1:0] adr_q, adr_nxt;   // only the last AW field bits survive
  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt_q;
  logic [WW-1:0] dsr_q;
  logic [BW-1:0] dbit_q;
  logic          so_q, oe_q, done_q, last_word;

  always_comb begin
    op_nxt    = {op_q[6:0], si_i};
    adr_nxt   = {adr_q[AW-2:0], si_i};
    rd_addr_o = (state_q == ST_ADR) ? adr_nxt : AW'(addr_q + 1'b1);
    last_word = (MODE == MODE_BASE) && (addr_q == TOP);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OPC;
      op_q    <= '0;
      adr_q   <= '0;
      addr_q  <= '0;
      cnt_q   <= '0;
      dsr_q   <= '0;
      dbit_q  <= '0;
      so_q    <= 1'b0;
      oe_q    <= 1'b0;
      done_q  <= 1'b0;
    end else if (cs_i) begin
      state_q <= ST_OPC;
      cnt_q   <= '0;
      dbit_q  <= '0;
      oe_q    <= 1'b0;
      done_q  <= 1'b0;
    end else if (sck_rise_i) begin
      unique case (state_q)
        ST_OPC: begin
          op_q  <= op_nxt;
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == OPC_LAST) begin
            cnt_q   <= '0;
            state_q <= (op_nxt == READ_OP && !busy_i) ? ST_ADR : ST_IGN;
          end
        end
        ST_ADR: begin
          adr_q <= adr_nxt;
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == ADR_LAST) begin
            addr_q  <= adr_nxt;
            dsr_q   <= rd_data_i;
            dbit_q  <= '0;
            state_q <= ST_DATA;
          end
        end
        default: ;
      endcase
    end else if (sck_fall_i && state_q == ST_DATA) begin
      if (done_q) begin
        oe_q <= 1'b0;
      end else begin
        oe_q <= 1'b1;
        so_q <= dsr_q[WW-1];
        if (dbit_q == BIT_LAST) begin
          dbit_q <= '0;
          addr_q <= addr_q + 1'b1;
          dsr_q  <= rd_data_i;
          if (last_word) done_q <= 1'b1;
        end else begin
          dsr_q  <= {dsr_q[WW-2:0], 1'b0};
          dbit_q <= dbit_q + 1'b1;
        end
      end
    end
  end

  assign so_o    = so_q;
  assign so_oe_o = oe_q;

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_i |=> !so_oe_o);

  assert_busy_refuse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_i && sck_rise_i && state_q == ST_OPC && cnt_q == OPC_LAST && busy_i)
    |=> state_q == ST_IGN);

  assert_drive_only_data_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    so_oe_o |-> state_q == ST_DATA);

  if (MODE == MODE_EXT) begin : g_ext
    assert_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cs_i && !sck_rise_i && sck_fall_i && state_q == ST_DATA
       && dbit_q == BIT_LAST && addr_q == TOP) |=> addr_q == '0);
  end else begin : g_base
    assert_stop_top_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cs_i && !sck_rise_i && sck_fall_i && state_q == ST_DATA && done_q)
      |=> !so_oe_o);
  end
endmodule

// File: rtl/spi_rd_slave.sv
module spi_rd_slave
  import spi_rd_pkg::*;
#(
  parameter mode_e MODE   = MODE_EXT,
  parameter int    AW     = (MODE == MODE_EXT) ? 9 : 8,
  parameter int    WW     = (MODE == MODE_EXT) ? 16 : 8,
  parameter int    FW     = (MODE == MODE_EXT) ? 16 : 8,
  parameter int    STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sck_i,
  input  logic          cs_ni,
  input  logic          si_i,
  input  logic          busy_i,
  input  logic          pre_we_i,
  input  logic [AW-1:0] pre_addr_i,
  input  logic [WW-1:0] pre_data_i,
  output logic          so_o,
  output logic          so_oe_o
);
  logic          sck_rise, sck_fall, cs_s, si_s;
  logic [AW-1:0] rd_addr;
  logic [WW-1:0] rd_data;

  spi_rd_sync #(.STAGES(STAGES)) u_sync (
    .clk_i, .rst_ni, .sck_i, .cs_ni, .si_i,
    .sck_rise_o(sck_rise), .sck_fall_o(sck_fall), .cs_o(cs_s), .si_o(si_s)
  );

  spi_rd_array #(.AW(AW), .WW(WW)) u_array (
    .clk_i, .we_i(pre_we_i), .waddr_i(pre_addr_i), .wdata_i(pre_data_i),
    .raddr_i(rd_addr), .rdata_o(rd_data)
  );

  spi_rd_ctrl #(.MODE(MODE), .AW(AW), .WW(WW), .FW(FW)) u_ctrl (
    .clk_i, .rst_ni, .sck_rise_i(sck_rise), .sck_fall_i(sck_fall),
    .cs_i(cs_s), .si_i(si_s), .busy_i,
    .rd_addr_o(rd_addr), .rd_data_i(rd_data), .so_o, .so_oe_o
  );
endmodule

// File: tb/spi_rd_slave_test.sv
module spi_rd_slave_test;
  import spi_rd_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;   // clk cycles per SCK half period

  logic clk = 0, rst_n = 0, sck = 0, si = 0, busy = 0;
  logic cs_e_n = 1, cs_b_n = 1, we_e = 0, we_b = 0;
  logic [8:0]  pa = '0;
  logic [15:0] pd = '0;
  logic so_e, oe_e, so_b, oe_b;
  int n_checks = 0, n_fail = 0, cycles = 0;

  typedef struct packed {bit base; bit oe; bit val; int req;} exp_t;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_rd_slave #(.MODE(MODE_EXT)) uut (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_e_n), .si_i(si),
    .busy_i(busy), .pre_we_i(we_e), .pre_addr_i(pa), .pre_data_i(pd),
    .so_o(so_e), .so_oe_o(oe_e));

  spi_rd_slave #(.MODE(MODE_BASE)) uut_base (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_b_n), .si_i(si),
    .busy_i(busy), .pre_we_i(we_b), .pre_addr_i(pa[7:0]), .pre_data_i(pd[7:0]),
    .so_o(so_b), .so_oe_o(oe_b));

  function automatic logic [15:0] ext_word(int a);
    return 16'((a * 40503) ^ (a << 7) ^ 16'h5a3c);
  endfunction
  function automatic logic [7:0] base_byte(int a);
    return 8'((a * 151) ^ 8'hc5);
  endfunction

  task automatic check(bit ok, int req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Monitor: pops one expectation per rising SCK of a selected transaction.
  always @(posedge sck) begin
    if (!cs_e_n || !cs_b_n) begin
      if (q.size() == 0) begin
        check(0, 5, "unexpected SCK edge", 0, 1);
      end else begin
        exp_t it;
        logic a_oe, a_so;
        it   = q.pop_front();
        a_oe = it.base ? oe_b : oe_e;
        a_so = it.base ? so_b : so_e;
        if (a_oe !== it.oe) check(0, it.req, "so_oe", int'(a_oe), int'(it.oe));
        else if (it.oe && a_so !== it.val) check(0, it.req, "so bit", int'(a_so), int'(it.val));
        else check(1, it.req, "", 0, 0);
      end
    end
  end

  task automatic send_bit(logic b);
    si = b;
    repeat (HALF) @(negedge clk);
    sck = 1;
    repeat (HALF) @(negedge clk);
    sck = 0;
  endtask

  // Driver: pushes expected output per SCK cycle, then shifts the transaction.
  task automatic read_tx(bit base, logic [7:0] op, logic [15:0] af, int ndata, bit bz, int req);
    int fw = base ? 8 : 16;
    int ww = base ? 8 : 16;
    bit ok = (op == 8'h03) && !bz;
    int a0 = base ? int'(af[7:0]) : int'(af[8:0]);
    for (int i = 0; i < 8 + fw; i++) q.push_back('{base, 1'b0, 1'b0, 5});
    for (int k = 0; k < ndata; k++) begin
      int a = a0 + k / ww;
      int bi = ww - 1 - k % ww;
      logic [15:0] w;
      if (!base) a = a % 512;
      if (!ok || (base && a > 255)) q.push_back('{base, 1'b0, 1'b0, req});
      else begin
        w = base ? {8'h00, base_byte(a)} : ext_word(a);
        q.push_back('{base, 1'b1, w[bi], req});
      end
    end
    busy = bz;
    @(negedge clk);
    if (base) cs_b_n = 0; else cs_e_n = 0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < 8; i++) send_bit(op[7-i]);
    for (int i = 0; i < fw; i++) send_bit(af[fw-1-i]);
    for (int i = 0; i < ndata; i++) send_bit(logic'(i % 3 == 1));
    repeat (HALF) @(negedge clk);
    cs_e_n = 1; cs_b_n = 1;
    repeat (4) @(negedge clk);
    // R1: select high releases SO
    check(oe_e === 1'b0 && oe_b === 1'b0, 1, "so_oe after deselect", int'(oe_e | oe_b), 0);
    repeat (2 * HALF) @(negedge clk);
    busy = 0;
    check(q.size() == 0, 5, "pending expectations", q.size(), 0);
    q.delete();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected <= 150000 cycles", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(oe_e === 1'b0 && oe_b === 1'b0, 1, "so_oe at reset", int'(oe_e | oe_b), 0);
    rst_n = 1;
    // R9: preload both arrays through the parallel port
    for (int a = 0; a < 512; a++) begin
      @(negedge clk); we_e = 1; pa = 9'(a); pd = ext_word(a);
    end
    @(negedge clk); we_e = 0;
    for (int a = 0; a < 256; a++) begin
      @(negedge clk); we_b = 1; pa = 9'(a); pd = {8'h00, base_byte(a)};
    end
    @(negedge clk); we_b = 0;
    repeat (4) @(negedge clk);

    read_tx(0, 8'h03, 16'h0005, 48, 0, 9);   // R9 R5: plain ext read, 3 words
    read_tx(0, 8'h03, 16'hfe13, 32, 0, 4);   // R4: upper 7 field bits set, discarded
    read_tx(0, 8'h03, 16'h01fe, 64, 0, 6);   // R6: 510,511,0,1
    read_tx(0, 8'h03, 16'h0040, 40, 1, 3);   // R3: busy refuses
    read_tx(0, 8'h0b, 16'h0040, 40, 0, 2);   // R2: wrong command
    read_tx(0, 8'h03, 16'h0100, 21, 0, 1);   // R1: cut mid-word
    read_tx(0, 8'h03, 16'h0100, 32, 0, 1);   // R1: fresh start after cut
    read_tx(1, 8'h03, 16'h0010, 24, 0, 7);   // R7: base bytes
    read_tx(1, 8'h03, 16'h00fd, 40, 0, 8);   // R8: 253..255 then released
    read_tx(1, 8'h03, 16'h0020, 16, 1, 3);   // R3: busy in base mode
    read_tx(1, 8'h83, 16'h0020, 16, 0, 2);   // R2: wrong command in base mode

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule